// File: doc/BRIEF.md
# Zero-Address Stack Execution Unit

This block is the execution core of a small stack machine. An instruction is a 3-bit opcode plus a memory address. It arrives over a valid/ready handshake. Arithmetic instructions name no operands at all. They take their two inputs from the top of an internal hardware stack and leave the single result there. Only the push and pop instructions use the address, and they move one word between the stack and a synchronous data memory.

A push issues a memory read in the cycle the instruction is accepted. The word comes back one cycle later, and during that cycle the unit is busy and refuses new instructions. A pop writes the top entry to memory in its acceptance cycle. Any fault is caught at acceptance, before the stack or memory is touched. An underfull stack, or a push into a full one, sets a sticky error flag and cancels the instruction. The current top of stack is always visible on an output.

Top module: `stack_exec_unit`

## Requirements
- R1: After reset the stack holds no entries, `tos_data` is 0, `busy`, `ovf_err` and `unf_err` are low and `instr_ready` is high.
- R2: A push (opcode 0) accepted on a non-full stack raises `mem_rd_en` in its acceptance cycle with `mem_addr` equal to `instr_addr`. In the following cycle `busy` is high and `instr_ready` is low. The word on `mem_rdata` in that cycle becomes `tos_data` from the next cycle on.
- R3: A pop (opcode 1) accepted on a non-empty stack raises `mem_wr_en` in its acceptance cycle, with `mem_addr` equal to `instr_addr` and `mem_wdata` equal to the top entry. The entry below then becomes the top.
- R4: Add (opcode 2) replaces the two top entries with their sum modulo 2^W.
- R5: Subtract (opcode 3) replaces the two top entries with the old top minus the entry beneath it, modulo 2^W.
- R6: Multiply (opcode 4) replaces the two top entries with the low W bits of their product.
- R7: An arithmetic opcode accepted with fewer than two entries sets `unf_err`, leaves the stack unchanged and does not access memory.
- R8: A pop accepted on an empty stack sets `unf_err` and does not raise `mem_wr_en`.
- R9: A push accepted with DEPTH entries present sets `ovf_err`, does not raise `mem_rd_en`, leaves the stack unchanged and does not drop `instr_ready`.
- R10: `ovf_err` and `unf_err` stay high once set until reset, while later valid instructions still execute.
- R11: Opcodes 5, 6 and 7 are accepted and change neither the stack, the flags nor memory.
- R12: The stack is last-in first-out and holds up to DEPTH (default 16) entries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_valid | input | 1 | An instruction is offered |
| instr_ready | output | 1 | The unit accepts an instruction this cycle |
| instr_op | input | 3 | Opcode: 0 push, 1 pop, 2 add, 3 subtract, 4 multiply |
| instr_addr | input | AW | Memory address for push and pop |
| mem_rd_en | output | 1 | Memory read strobe; data is returned one cycle later |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | W | Memory write data |
| mem_rdata | input | W | Memory read data |
| tos_data | output | W | Current top entry, 0 when empty |
| busy | output | 1 | A memory read is in flight |
| ovf_err | output | 1 | Sticky overflow flag |
| unf_err | output | 1 | Sticky underflow flag |

## Verification
The hardest state to reach from the ports is a completely full stack, because sixteen memory-backed pushes are needed before a push can be refused. The stimulus makes those pushes from distinct addresses. It then offers a seventeenth push and checks that no read strobe and no busy cycle follow. After that it drains all sixteen entries through pops, which confirms the last-in first-out order and the memory writes. Underflow on an arithmetic opcode needs exactly one entry on the stack. It is reached with a single push after a reset, and a later push checks that the flag stays set.

// File: rtl/stk_pkg.sv
package stk_pkg;
   localparam int OPC_W = 3;

   typedef enum logic [OPC_W-1:0] {
      OPC_PUSH = 3'd0,
      OPC_POP  = 3'd1,
      OPC_ADD  = 3'd2,
      OPC_SUB  = 3'd3,
      OPC_MUL  = 3'd4
   } opc_e;

   typedef enum logic [0:0] {
      SEQ_IDLE = 1'b0,
      SEQ_FILL = 1'b1
   } seq_e;
endpackage

// File: rtl/stk_alu.sv
module stk_alu
   import stk_pkg::*;
#(
   parameter int W = 16
) (
   input  logic [OPC_W-1:0] op,
   input  logic [W-1:0]     a_top,
   input  logic [W-1:0]     b_next,
   output logic [W-1:0]     y
);
   logic [W-1:0] prod;

   // Narrow words form the full product and slice it; wide words keep only W bits.
   generate
      if (W <= 32) begin : g_mul_full
         logic [2*W-1:0] wide;
         assign wide = a_top * b_next;
         assign prod = wide[W-1:0];
      end else begin : g_mul_trunc
         assign prod = W'(a_top * b_next);
      end
   endgenerate

   always_comb begin
      case (op)
         OPC_ADD: y = a_top + b_next;
         OPC_SUB: y = a_top - b_next;
         OPC_MUL: y = prod;
         default: y = '0;
      endcase
   end
endmodule

// File: rtl/stk_file.sv
module stk_file #(
   parameter int W     = 16,
   parameter int DEPTH = 16,
   localparam int CW   = $clog2(DEPTH + 1),
   localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push_en,
   input  logic          pop_en,
   input  logic          rep_en,
   input  logic [W-1:0]  wr_data,
   output logic [CW-1:0] count,
   output logic [W-1:0]  top,
   output logic [W-1:0]  next
);
   logic [W-1:0] ent [DEPTH];
   logic [IW-1:0] top_idx, next_idx;

   assign top_idx  = IW'(count - CW'(1));
   assign next_idx = IW'(count - CW'(2));
   assign top  = (count == '0) ? '0 : ent[top_idx];
   assign next = (count < CW'(2)) ? '0 : ent[next_idx];

   // Each entry is written by a push landing on it or by an arithmetic result landing on it.
   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_ent
         logic hit;
         assign hit = (push_en && count == CW'(i)) ||
                      (rep_en && count == CW'(i + 2));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   ent[i] <= '0;
            else if (hit) ent[i] <= wr_data;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 count <= '0;
      else if (push_en)           count <= count + CW'(1);
      else if (pop_en || rep_en)  count <= count - CW'(1);
   end

   assert_depth_bound_R12: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));
   assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      push_en |-> count < CW'(DEPTH));
   assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      pop_en |-> count != '0);
   assert_two_operands_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rep_en |-> count >= CW'(2));
   assert_one_update_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({push_en, pop_en, rep_en}));
endmodule

// File: rtl/stk_ctrl.sv
module stk_ctrl
   import stk_pkg::*;
#(
   parameter int DEPTH = 16,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             instr_valid,
   input  logic [OPC_W-1:0] instr_op,
   input  logic [CW-1:0]    count,
   output logic             instr_ready,
   output logic             busy,
   output logic             mem_rd_en,
   output logic             mem_wr_en,
   output logic             push_en,
   output logic             pop_en,
   output logic             rep_en,
   output logic             ovf_err,
   output logic             unf_err
);
   seq_e state;
   logic accept, is_push, is_pop, is_arith;
   logic full, empty, two_ok, ovf_set, unf_set;

   always_comb begin
      accept   = instr_valid && (state == SEQ_IDLE);
      is_push  = (instr_op == OPC_PUSH);
      is_pop   = (instr_op == OPC_POP);
      is_arith = (instr_op == OPC_ADD) || (instr_op == OPC_SUB) || (instr_op == OPC_MUL);
      full     = (count == CW'(DEPTH));
      empty    = (count == '0);
      two_ok   = (count >= CW'(2));
      mem_rd_en = accept && is_push && !full;
      mem_wr_en = accept && is_pop && !empty;
      pop_en    = mem_wr_en;
      rep_en    = accept && is_arith && two_ok;
      push_en   = (state == SEQ_FILL);
      ovf_set   = accept && is_push && full;
      unf_set   = accept && ((is_pop && empty) || (is_arith && !two_ok));
      instr_ready = (state == SEQ_IDLE);
      busy        = (state == SEQ_FILL);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= SEQ_IDLE;
         ovf_err <= 1'b0;
         unf_err <= 1'b0;
      end else begin
         state   <= mem_rd_en ? SEQ_FILL : SEQ_IDLE;
         ovf_err <= ovf_err | ovf_set;
         unf_err <= unf_err | unf_set;
      end
   end

   assert_fill_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |=> busy && !instr_ready);
   assert_single_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !busy);
   assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_err |=> ovf_err);
   assert_unf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      unf_err |=> unf_err);
   assert_ovf_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_err) |-> $past(instr_valid && instr_op == OPC_PUSH));
   assert_no_mem_clash_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd_en && mem_wr_en));
endmodule

// File: rtl/stack_exec_unit.sv
module stack_exec_unit
   import stk_pkg::*;
#(
   parameter int W     = 16,
   parameter int DEPTH = 16,
   parameter int AW    = 8,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             instr_valid,
   output logic             instr_ready,
   input  logic [OPC_W-1:0] instr_op,
   input  logic [AW-1:0]    instr_addr,
   output logic             mem_rd_en,
   output logic             mem_wr_en,
   output logic [AW-1:0]    mem_addr,
   output logic [W-1:0]     mem_wdata,
   input  logic [W-1:0]     mem_rdata,
   output logic [W-1:0]     tos_data,
   output logic             busy,
   output logic             ovf_err,
   output logic             unf_err
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("stack_exec_unit: DEPTH must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("stack_exec_unit: W must be positive");
      end
      if (AW < 1) begin : g_bad_addr
         $error("stack_exec_unit: AW must be positive");
      end
   endgenerate

   logic [CW-1:0] count;
   logic [W-1:0]  top, next, alu_y, wr_data;
   logic          push_en, pop_en, rep_en;

   stk_ctrl #(.DEPTH(DEPTH)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .instr_valid(instr_valid), .instr_op(instr_op), .count(count),
      .instr_ready(instr_ready), .busy(busy),
      .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
      .push_en(push_en), .pop_en(pop_en), .rep_en(rep_en),
      .ovf_err(ovf_err), .unf_err(unf_err)
   );

   stk_alu #(.W(W)) u_alu (
      .op(instr_op), .a_top(top), .b_next(next), .y(alu_y)
   );

   assign wr_data = push_en ? mem_rdata : alu_y;

   stk_file #(.W(W), .DEPTH(DEPTH)) u_file (
      .clk(clk), .rst_n(rst_n),
      .push_en(push_en), .pop_en(pop_en), .rep_en(rep_en),
      .wr_data(wr_data), .count(count), .top(top), .next(next)
   );

   assign mem_addr  = instr_addr;
   assign mem_wdata = top;
   assign tos_data  = top;
endmodule

// File: tb/stack_exec_unit_bench.sv
`timescale 1ns/1ps
module stack_exec_unit_bench;
   localparam int W = 16, DEPTH = 16, AW = 8;

   logic clk = 1'b0, rst_n = 1'b0;
   logic instr_valid = 1'b0;
   logic [2:0] instr_op = '0;
   logic [AW-1:0] instr_addr = '0;
   logic instr_ready, mem_rd_en, mem_wr_en, busy, ovf_err, unf_err;
   logic [AW-1:0] mem_addr;
   logic [W-1:0] mem_wdata, tos_data;
   logic [W-1:0] mem_rdata = '0;

   always #2 clk = ~clk;

   stack_exec_unit #(.W(W), .DEPTH(DEPTH), .AW(AW)) u_stack_exec_unit (
      .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_ready(instr_ready),
      .instr_op(instr_op), .instr_addr(instr_addr), .mem_rd_en(mem_rd_en),
      .mem_wr_en(mem_wr_en), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .tos_data(tos_data), .busy(busy),
      .ovf_err(ovf_err), .unf_err(unf_err)
   );

   // Synchronous data memory; contents start as a computed pattern.
   logic [W-1:0] bmem [256];
   always @(posedge clk) begin
      if (mem_rd_en) mem_rdata <= bmem[mem_addr];
      if (mem_wr_en) bmem[mem_addr] <= mem_wdata;
   end

   int n_checks = 0, n_fail = 0;
   bit done = 0;
   int model[$];
   int shadow[256];
   bit m_ovf = 0, m_unf = 0;

   typedef struct { int tos; bit ovf; bit unf; string req; } exp_t;
   exp_t exp_q[$];
   event sb_ev;

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   // Monitor: compares every queued expectation with the outputs.
   always @(sb_ev) begin
      while (exp_q.size() > 0) begin
         exp_t e;
         e = exp_q.pop_front();
         chk(int'(tos_data) == e.tos, {e.req, " tos"}, int'(tos_data), e.tos);
         chk(ovf_err == e.ovf, {e.req, " ovf_err"}, int'(ovf_err), int'(e.ovf));
         chk(unf_err == e.unf, {e.req, " unf_err"}, int'(unf_err), int'(e.unf));
      end
   end

   function automatic int exp_tos();
      return (model.size() > 0) ? model[$] : 0;
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      model.delete();
      m_ovf = 0; m_unf = 0;
      @(negedge clk);
      chk(instr_ready == 1'b1, "R1 ready", int'(instr_ready), 1);
      chk(busy == 1'b0, "R1 busy", int'(busy), 0);
      exp_q.push_back('{0, 1'b0, 1'b0, "R1 reset"});
      -> sb_ev;
   endtask

   // Driver: issues one instruction, checks memory strobes, queues the expectation.
   task automatic run_op(input int op, input int addr, input string req);
      bit full, fill;
      full = (model.size() == DEPTH);
      @(negedge clk);
      instr_valid = 1'b1; instr_op = 3'(op); instr_addr = AW'(addr);
      #0.5;
      if (op == 0) begin
         chk(mem_rd_en == !full, {req, " R2/R9 rd_en"}, int'(mem_rd_en), int'(!full));
         if (!full) chk(int'(mem_addr) == addr, {req, " R2 addr"}, int'(mem_addr), addr);
      end else begin
         chk(mem_rd_en == 1'b0, {req, " rd_en idle"}, int'(mem_rd_en), 0);
      end
      if (op == 1 && model.size() > 0) begin
         chk(mem_wr_en == 1'b1, {req, " R3 wr_en"}, int'(mem_wr_en), 1);
         chk(int'(mem_wdata) == model[$], {req, " R3 wdata"}, int'(mem_wdata), model[$]);
         chk(int'(mem_addr) == addr, {req, " R3 addr"}, int'(mem_addr), addr);
      end else begin
         chk(mem_wr_en == 1'b0, {req, " R8 wr_en"}, int'(mem_wr_en), 0);
      end
      fill = (op == 0) && !full;
      @(negedge clk);
      instr_valid = 1'b0;
      if (fill) begin
         chk(busy == 1'b1, {req, " R2 busy"}, int'(busy), 1);
         chk(instr_ready == 1'b0, {req, " R2 ready"}, int'(instr_ready), 0);
         @(negedge clk);
      end else begin
         chk(busy == 1'b0, {req, " R9 no busy"}, int'(busy), 0);
      end
      case (op)
         0: if (full) m_ovf = 1; else model.push_back(shadow[addr]);
         1: if (model.size() == 0) m_unf = 1;
            else shadow[addr] = model.pop_back();
         2, 3, 4: if (model.size() < 2) m_unf = 1;
            else begin
               int a, b, r;
               a = model.pop_back(); b = model.pop_back();
               r = (op == 2) ? a + b : (op == 3) ? a - b : a * b;
               model.push_back(r & 32'hFFFF);
            end
         default: ;
      endcase
      exp_q.push_back('{exp_tos(), m_ovf, m_unf, req});
      -> sb_ev;
   endtask

   initial begin
      for (int i = 0; i < 256; i++) begin
         shadow[i] = (i * 37 + 5) & 32'hFFFF;
         bmem[i] = W'(shadow[i]);
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      do_reset();                         // R1
      run_op(0, 3, "R2 push a");
      run_op(0, 7, "R2 push b");
      run_op(3, 0, "R5 sub");
      run_op(0, 20, "R2 push c");
      run_op(2, 0, "R4 add");
      run_op(0, 250, "R2 push d");
      run_op(0, 251, "R2 push e");
      run_op(4, 0, "R6 mul");
      run_op(2, 0, "R4 add wrap");
      run_op(6, 9, "R11 undefined 6");
      run_op(7, 9, "R11 undefined 7");
      run_op(0, 1, "R12 push f");
      run_op(1, 200, "R3 pop");
      run_op(0, 200, "R3 readback");
      run_op(5, 0, "R11 undefined 5");
      do_reset();
      run_op(0, 40, "R7 single push");
      run_op(4, 0, "R7 mul underfull");
      run_op(3, 0, "R7 sub underfull");
      run_op(0, 41, "R10 push after unf");
      do_reset();
      run_op(1, 60, "R8 pop empty");
      run_op(2, 0, "R7 add empty");
      do_reset();
      for (int i = 0; i < DEPTH; i++) run_op(0, 100 + i, "R12 fill");
      run_op(0, 150, "R9 push full");
      run_op(1, 210, "R10 pop after ovf");
      run_op(0, 151, "R12 refill");
      for (int i = 0; i < DEPTH; i++) run_op(1, 220 + i, "R12 drain");
      run_op(1, 240, "R8 pop after drain");
      repeat (2) @(negedge clk);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule